// File: doc/BRIEF.md
# Serial Flash Image Loader

This block fetches a stored image from a serial flash device over a four-wire SPI link, acting as the bus master. A one-cycle `start` pulse triggers a single read command: eight opcode bits and a 24-bit start address, then a selectable run of dummy clocks. After that the block keeps clocking until the requested number of bytes has arrived. The opcode and the dummy count come from a 3-bit variant code, which lets one design serve flash families that use different read instructions. Once the command has been sent, the flash streams the image without further instructions, and chip select stays low for the whole exchange.

Received data leaves the block in two forms. A serial tap reports each data bit with a one-cycle strobe. A byte port uses a valid/ready handshake. A completed byte is held on `byte_data` with `byte_valid` high until the consumer raises `byte_ready`. While a byte waits unaccepted, the serial clock stops in its current level, so back-pressure never loses data; it only stretches the transfer. The serial tap has no ready, and it pauses with the clock.

The serial clock runs in mode 0 and is derived from the system clock. Each level lasts `div_half + 1` system cycles, so a 200 MHz system clock with a setting of 4 yields 20 MHz. The hold and write-protect lines to the flash are driven inactive (high) at all times.

Top module: `spi_img_loader`

## Requirements
- R1: After synchronous reset, `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `err`, `bit_valid` and `byte_valid` are 0.
- R2: An accepted start lowers `cs_n` and sends 32 command bits on `mosi`, MSB first: the opcode byte, then `start_addr[23:0]`. `mosi` changes only while `sclk` falls and is stable at each rising `sclk`; `sclk` idles low.
- R3: The variant code selects the opcode and the dummy-bit count: 3'b000 gives 0x03 with 0 dummy bits, 3'b001 gives 0x0B with 8, 3'b010 gives 0x0B with 16, and 3'b011 gives 0xE8 with 32.
- R4: A start with variant codes 3'b100 to 3'b111, or with `length` equal to 0, sets `err`. In that case `cs_n` stays high, `busy` stays 0 and no clock is produced. `err` stays set until the next accepted start clears it.
- R5: After the dummy bits, `miso` is sampled at every rising `sclk`. Each sample appears on `bit_data` with a one-cycle `bit_valid`, in arrival order.
- R6: Every 8 data bits form one byte, the first received bit in bit 7. `byte_valid` with `byte_data` holds until `byte_ready` is high at a clock edge. While a byte is held and not accepted, `sclk` does not change.
- R7: A transfer has exactly 32 + dummy + 8*`length` rising `sclk` edges, all with `cs_n` low. After the last one, `sclk` returns low. On that same edge `cs_n` rises and `done` pulses for exactly one cycle.
- R8: Without back-pressure, each `sclk` high level lasts `div_half + 1` system cycles; the setting is captured at start.
- R9: A `start` pulse while `busy` is 1 is ignored; the running transfer completes with its original parameters and a single `done`.
- R10: Reset asserted during a transfer leaves `cs_n` high, `sclk` low, `busy` 0 and `byte_valid` 0 after the next edge, and a following start works normally.
- R11: `hold_n` and `wp_n` are 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a read |
| variant | input | 3 | Read variant code (opcode and dummy count) |
| start_addr | input | 24 | Flash byte address of the image |
| length | input | LEN_W | Number of bytes to read |
| div_half | input | DIV_W | Serial clock half period minus one, in system cycles |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial command data to the flash |
| miso | input | 1 | Serial data from the flash |
| hold_n | output | 1 | Flash hold line, kept high |
| wp_n | output | 1 | Flash write-protect line, kept high |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| err | output | 1 | Last start request was rejected |
| bit_valid | output | 1 | Strobe for one received data bit |
| bit_data | output | 1 | Received data bit |
| byte_valid | output | 1 | Packed byte available |
| byte_ready | input | 1 | Consumer accepts the packed byte |
| byte_data | output | 8 | Packed byte, first received bit in bit 7 |

## Verification
The hardest state to reach from the ports is a frozen serial clock: a complete byte is held while the consumer refuses it, and the link must neither advance nor corrupt the waiting byte. A dedicated run keeps `byte_ready` low until the first byte appears, watches `sclk` and `byte_data` for many cycles, then releases it and checks the whole image. Random runs repeat this at finer grain by dropping ready on about a quarter of cycles. A start arriving mid-transfer and a reset during streaming are driven at fixed points inside a long read, and the flash model derives its data from the address it actually received.

// File: rtl/spi_img_pkg.sv
package spi_img_pkg;

  localparam int ADDR_W   = 24;
  localparam int OP_W     = 8;
  localparam int CMD_BITS = OP_W + ADDR_W;
  localparam int BYTE_W   = 8;
  localparam int DUMMY_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_TAIL
  } ld_state_t;

  typedef struct packed {
    logic               ok;
    logic [OP_W-1:0]    opcode;
    logic [DUMMY_W-1:0] dummy;
  } rd_variant_t;

  // Variant code to read instruction and dummy clock count.
  function automatic rd_variant_t decode_variant(input logic [2:0] code);
    rd_variant_t r;
    r = '0;
    case (code)
      3'b000: begin r.ok = 1'b1; r.opcode = 8'h03; r.dummy = 6'd0;  end
      3'b001: begin r.ok = 1'b1; r.opcode = 8'h0B; r.dummy = 6'd8;  end
      3'b010: begin r.ok = 1'b1; r.opcode = 8'h0B; r.dummy = 6'd16; end
      3'b011: begin r.ok = 1'b1; r.opcode = 8'hE8; r.dummy = 6'd32; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_img_sclk.sv
module spi_img_sclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick = run && adv && (cnt == div);
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (adv) begin
      if (cnt == div) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_img_packer.sv
module spi_img_packer
  import spi_img_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              take,
  output logic              valid,
  output logic [BYTE_W-1:0] data
);

  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-2:0] sr;
  logic [IDX_W-1:0]  idx;
  logic              last;

  assign last = (idx == IDX_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sr    <= '0;
      idx   <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (valid && take) valid <= 1'b0;
      if (bit_en) begin
        sr  <= {sr[BYTE_W-3:0], bit_in};
        idx <= last ? '0 : idx + 1'b1;
        if (last) begin
          data  <= {sr, bit_in};
          valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_img_loader.sv
module spi_img_loader
  import spi_img_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        variant,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic [DIV_W-1:0]  div_half,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              hold_n,
  output logic              wp_n,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bit_valid,
  output logic              bit_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic [BYTE_W-1:0] byte_data
);

  localparam int CNT_W = LEN_W + 4;

  ld_state_t             state;
  rd_variant_t           dec;
  logic                  launch;
  logic                  reject;
  logic [CMD_BITS-1:0]   cmd_sr;
  logic [CNT_W-1:0]      edge_cnt;
  logic [CNT_W-1:0]      edge_last;
  logic [CNT_W-1:0]      data_from;
  logic [DIV_W-1:0]      div_q;
  logic                  rise;
  logic                  fall;
  logic                  stall;
  logic                  data_bit;

  assign dec    = decode_variant(variant);
  assign launch = (state == ST_IDLE) && start && dec.ok && (length != '0);
  assign reject = (state == ST_IDLE) && start && !(dec.ok && (length != '0));

  assign busy   = (state != ST_IDLE);
  assign mosi   = cmd_sr[CMD_BITS-1];
  assign hold_n = 1'b1;
  assign wp_n   = 1'b1;

  assign stall    = byte_valid && !byte_ready;
  assign data_bit = (state == ST_XFER) && rise && (edge_cnt >= data_from);

  spi_img_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .adv  (!stall),
    .div  (div_q),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  spi_img_packer u_pack (
    .clk    (clk),
    .rst    (rst),
    .clear  (launch),
    .bit_en (data_bit),
    .bit_in (miso),
    .take   (byte_ready),
    .valid  (byte_valid),
    .data   (byte_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      cmd_sr    <= '0;
      edge_cnt  <= '0;
      edge_last <= '0;
      data_from <= '0;
      div_q     <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      done      <= 1'b0;
      bit_valid <= data_bit;
      if (data_bit) bit_data <= miso;
      unique case (state)
        ST_IDLE: begin
          if (reject) err <= 1'b1;
          if (launch) begin
            err       <= 1'b0;
            cs_n      <= 1'b0;
            cmd_sr    <= {dec.opcode, start_addr};
            edge_cnt  <= '0;
            data_from <= CNT_W'(CMD_BITS) + CNT_W'(dec.dummy);
            edge_last <= CNT_W'(CMD_BITS) + CNT_W'(dec.dummy)
                         + {1'b0, length, 3'b000} - 1'b1;
            div_q     <= div_half;
            state     <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (fall) cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
          if (rise) begin
            if (edge_cnt == edge_last) state <= ST_TAIL;
            else edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (fall) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_img_checker.sv
module spi_img_checker (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data
);

  // R7: the clock only leaves idle while the flash is selected
  a_r7_sclk_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R7: completion pulse lasts one cycle and coincides with deselect
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_deselected: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !sclk && !busy));

  // R4: a rejected request never selects the flash
  a_r4_err_no_select: assert property (@(posedge clk) disable iff (rst)
    err |-> cs_n);

  // R6: an unaccepted byte stays put and the link stops
  a_r6_byte_held: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  a_r6_sclk_frozen: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> $stable(sclk));

  // R10: reset deselects and idles the link
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (cs_n && !sclk && !busy && !byte_valid));

endmodule

bind spi_img_loader spi_img_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data)
);

// File: tb/spi_img_loader_bench.sv
module spi_img_loader_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  variant = 3'd0;
  logic [23:0] start_addr = '0;
  logic [15:0] length = '0;
  logic [7:0]  div_half = '0;
  logic        cs_n, sclk, mosi, hold_n, wp_n, busy, done, err;
  logic        bit_valid, bit_data, byte_valid;
  logic        byte_ready = 1'b1;
  logic [7:0]  byte_data;
  logic        miso = 1'b0;

  always #5 clk = ~clk;

  spi_img_loader u_spi_img_loader (
    .clk(clk), .rst(rst), .start(start), .variant(variant),
    .start_addr(start_addr), .length(length), .div_half(div_half),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
    .hold_n(hold_n), .wp_n(wp_n), .busy(busy), .done(done), .err(err),
    .bit_valid(bit_valid), .bit_data(bit_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data)
  );

  int total = 0;
  int failed = 0;

  // ---------- expected values from the requirements ----------
  function automatic logic [7:0] exp_op(input int v);
    case (v)
      0: return 8'h03;
      1: return 8'h0B;
      2: return 8'h0B;
      3: return 8'hE8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int exp_dummy(input int v);
    case (v)
      0: return 0;
      1: return 8;
      2: return 16;
      3: return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] fdata(input logic [23:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd29;
    return t ^ a[15:8] ^ {a[2:0], 5'b10110} ^ a[23:16];
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  // ---------- flash model ----------
  int          sel_id = 0;
  int          seen_id = 0;
  int          rises = 0;
  int          bad_rise = 0;
  int          m_dummy = 0;
  logic [31:0] cap = '0;
  logic [23:0] m_addr = '0;

  always @(negedge cs_n) sel_id++;

  always @(posedge sclk) begin
    if (cs_n) bad_rise++;
    else begin
      if (sel_id != seen_id) begin
        seen_id = sel_id;
        rises = 0;
      end
      if (rises < 32) cap = {cap[30:0], mosi};
      rises++;
      if (rises == 32) m_addr = cap[23:0];
    end
  end

  always @(negedge sclk) begin
    if (!cs_n) begin
      int idx;
      logic [7:0] b;
      idx = rises - 32 - m_dummy;
      if (idx >= 0) begin
        b = fdata(m_addr + 24'(idx / 8));
        miso = b[7 - (idx % 8)];
      end
    end
  end

  // ---------- monitor and consumer ----------
  int          rdy_mode = 0;
  int          cur_div = 0;
  logic [23:0] cur_addr = '0;
  int          got_n = 0;
  logic [7:0]  got [0:63];
  int          bit_n = 0;
  int          bit_bad = 0;
  int          done_n = 0;
  int          done_bad = 0;
  int          per_bad = 0;
  int          hi_run = 0;
  logic        prev_sclk = 1'b0;
  bit          cs_seen = 1'b0;
  int          cycles = 0;

  always @(negedge clk) begin
    case (rdy_mode)
      0: byte_ready = 1'b1;
      1: byte_ready = ($urandom % 4) != 0;
      default: byte_ready = 1'b0;
    endcase
    #1;
    cycles++;
    if (byte_valid && byte_ready) begin
      if (got_n < 64) got[got_n] = byte_data;
      got_n++;
    end
    if (bit_valid) begin
      logic [7:0] eb;
      eb = fdata(cur_addr + 24'(bit_n / 8));
      if (bit_data !== eb[7 - (bit_n % 8)]) bit_bad++;
      bit_n++;
    end
    if (done) begin
      done_n++;
      if (!cs_n || sclk) done_bad++;
    end
    if (!cs_n) cs_seen = 1'b1;
    if (sclk) hi_run++;
    else begin
      if (prev_sclk && rdy_mode == 0 && hi_run != cur_div + 1) per_bad++;
      hi_run = 0;
    end
    prev_sclk = sclk;
    if (cycles > 150000) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      report();
    end
  end

  // ---------- sequences ----------
  task automatic launch(input int v, input logic [23:0] a, input int len, input int dv, input int mode);
    @(negedge clk);
    variant = 3'(v); start_addr = a; length = 16'(len); div_half = 8'(dv);
    cur_div = dv; cur_addr = a; rdy_mode = mode; m_dummy = exp_dummy(v);
    got_n = 0; bit_n = 0; bit_bad = 0; done_n = 0; done_bad = 0; per_bad = 0;
    cs_seen = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_done();
    int n;
    n = 0;
    while (done_n == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input int v, input logic [23:0] a, input int len, input bit chk_period);
    int mism;
    logic [31:0] ecmd;
    ecmd = {exp_op(v), a};
    check(cap[31:8] == ecmd[31:8], "R3 opcode and upper address", cap[31:24], ecmd[31:24]);
    check(cap == ecmd, "R2 command word", cap, ecmd);
    check(rises == 32 + exp_dummy(v) + 8 * len, "R7 rising edge count", rises, 32 + exp_dummy(v) + 8 * len);
    check(bit_n == 8 * len && bit_bad == 0, "R5 serial data bits", bit_bad, 0);
    mism = 0;
    for (int k = 0; k < len && k < 64; k++)
      if (got[k] !== fdata(a + 24'(k))) mism++;
    check(got_n == len && mism == 0, "R6 packed bytes", got_n * 1000 + mism, len * 1000);
    check(done_n == 1 && done_bad == 0, "R7 single done with deselect", done_n, 1);
    check(bad_rise == 0, "R7 no clock while deselected", bad_rise, 0);
    check(err == 1'b0, "R4 err clear after accepted start", err, 0);
    if (chk_period) check(per_bad == 0, "R8 high level length", per_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !busy && !done && !err && !byte_valid && !bit_valid,
          "R1 reset state", {cs_n, sclk, busy, done, err, byte_valid}, 6'b100000);
    check(hold_n && wp_n, "R11 hold and write protect high", {hold_n, wp_n}, 2'b11);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // directed: each variant, several dividers, wrap of the address
    launch(0, 24'h000100, 1, 0, 0); await_done(); verify(0, 24'h000100, 1, 1);
    launch(1, 24'h123456, 3, 2, 0); await_done(); verify(1, 24'h123456, 3, 1);
    launch(2, 24'hFFFFFE, 4, 1, 0); await_done(); verify(2, 24'hFFFFFE, 4, 1);
    launch(3, 24'hA5A5A5, 2, 3, 0); await_done(); verify(3, 24'hA5A5A5, 2, 1);
    check(hold_n && wp_n, "R11 hold and write protect after reads", {hold_n, wp_n}, 2'b11);

    // R4: reserved codes and zero length
    for (int v = 4; v < 8; v++) begin
      launch(v, 24'h000200, 2, 0, 0);
      repeat (40) @(negedge clk);
      check(err && !cs_seen && !busy && done_n == 0, "R4 reserved code rejected",
            {err, cs_seen, busy}, 3'b100);
    end
    launch(1, 24'h000300, 0, 0, 0);
    repeat (40) @(negedge clk);
    check(err && !cs_seen && !busy, "R4 zero length rejected", {err, cs_seen, busy}, 3'b100);

    // R6: consumer refuses the first byte for a while
    begin
      int bad, n;
      logic s;
      logic [7:0] d;
      launch(1, 24'h00ABCD, 3, 1, 2);
      n = 0;
      while (!byte_valid && n < 5000) begin @(negedge clk); n++; end
      s = sclk; d = byte_data; bad = 0;
      repeat (25) begin
        @(negedge clk);
        if (sclk !== s || !byte_valid || byte_data !== d) bad++;
      end
      check(bad == 0 && n < 5000, "R6 link frozen while byte waits", bad, 0);
      rdy_mode = 0;
      await_done(); verify(1, 24'h00ABCD, 3, 0);
    end

    // R9: start while busy is ignored
    launch(0, 24'h004000, 4, 1, 0);
    repeat (60) @(negedge clk);
    variant = 3'd2; start_addr = 24'h777777; length = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    await_done();
    verify(0, 24'h004000, 4, 1);
    check(!busy, "R9 no second transfer", busy, 0);

    // R10: reset in the middle of streaming
    launch(3, 24'h0C0C0C, 8, 1, 1);
    repeat (120) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cs_n && !sclk && !busy && !byte_valid, "R10 reset mid transfer",
          {cs_n, sclk, busy, byte_valid}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    launch(2, 24'h00F00F, 2, 0, 0); await_done(); verify(2, 24'h00F00F, 2, 1);

    // random transfers with random back-pressure
    for (int i = 0; i < 12; i++) begin
      int v, len, dv, mode;
      logic [23:0] a;
      v = $urandom % 4; len = 1 + $urandom % 8; dv = $urandom % 4;
      mode = ($urandom % 2 == 0) ? 1 : 0;
      a = 24'($urandom);
      launch(v, a, len, dv, mode); await_done(); verify(v, a, len, mode == 0);
    end

    report();
  end

endmodule